// File: doc/BRIEF.md
# Frame Address Queue Manager

This block keeps the buffer-address queues that sit between a host processor and a fast Ethernet MAC. The host reaches it through single-cycle 32-bit register writes and reads. On the egress side the host stages a transmit buffer address and then commits it together with the frame length. On the ingress side it hands over empty receive buffers one address at a time. The MAC sees the oldest entry of each queue on dedicated head ports. It retires an egress entry with a transmit-done strobe, and it consumes a receive buffer with a receive-done strobe that carries the received length.

Both queues live in one shared 64-entry address store. A depth register splits that store into an egress region at the bottom and an ingress region directly above it. Completed receive frames are counted. The host reads the latest length and drains the pending count through a descriptor register. A receive event pulse is produced either after a programmable number of frames or after a programmable idle time with at least one frame outstanding.

Top module: `faq_mgr`

Register offsets: 0x00 status, 0x04 egress address, 0x08 egress length, 0x0C ingress address, 0x10 receive descriptor, 0x14 depth split, 0x18 coalescing. Other offsets read as zero and ignore writes.

## Requirements
- R1: After reset, status reads 0x03000000, the depth register reads 0x0000340C (egress 12, ingress 52), the coalescing register reads 0x08000074, and both head-valid outputs and rx_event are low.
- R2: A write to 0x14 takes the egress depth from bits 7:0 and the ingress depth from bits 15:8. The write is accepted only if both values are nonzero and their sum is at most 64. The register reads back the split as {16'h0, ingress, egress}. A rejected write changes nothing.
- R3: A write to 0x04 stages an egress address. The next write to 0x08 commits that address with the length in bits 11:0, and status bits 5:0 count the committed entries. A length write with no staged address is ignored, and every length write consumes the staged address.
- R4: tx_head_valid is high while the egress queue holds an entry. tx_head_addr and tx_head_len then show the oldest entry. tx_done removes it, and tx_done on an empty queue is ignored.
- R5: Status bit 24 is 1 when the egress count is below its depth, and bit 25 is 1 when the ingress count is below its depth. A push in the same cycle as a pop is still refused when the queue was full.
- R6: A commit to a full egress queue, or an ingress address write to a full ingress queue, is dropped. The drop sets a sticky flag, status bit 26 for egress and bit 27 for ingress. Writing 0x00 with bit 26 or bit 27 set clears the matching flag.
- R7: A write to 0x0C adds a receive buffer. rx_buf_valid and rx_buf_addr show the oldest buffer. rx_done with rx_len removes it and records one completed frame, and rx_done on an empty queue is ignored.
- R8: The descriptor at 0x10 reads {1'b0, ingress count[6:0], pending[7:0], 4'h0, last length[11:0]}. A read of 0x10 with rd_en high lowers the pending count by one when it is nonzero. The pending count saturates at 255.
- R9: rx_event pulses high for one cycle right after the edge that accepts the frame that brings the count since the last pulse up to the threshold in bits 31:24 of 0x18. A threshold of 0 acts as 1.
- R10: While at least one frame is counted, a timer advances each cycle, and rx_event pulses when it reaches the value in bits 15:0 of 0x18. Every pulse clears both the frame count and the timer. No pulse occurs with nothing counted.
- R11: An accepted depth write empties both queues and discards a staged egress address, and any pop requested in that cycle is ignored. The overflow flags and the coalescing state are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe (side effect only at 0x10) |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| tx_head_valid | output | 1 | Egress queue holds an entry |
| tx_head_addr | output | 32 | Oldest egress buffer address |
| tx_head_len | output | 12 | Oldest egress frame length |
| tx_done | input | 1 | MAC retires the oldest egress entry |
| rx_buf_valid | output | 1 | Ingress queue holds a buffer |
| rx_buf_addr | output | 32 | Oldest free receive buffer address |
| rx_done | input | 1 | MAC filled the oldest receive buffer |
| rx_len | input | 12 | Length of the frame finished with rx_done |
| rx_event | output | 1 | Coalesced receive event pulse |

## Verification
A corrupted ring pointer or count shows at the head ports or in the status word within one cycle. The wrong address or length then appears on tx_head or rx_buf at once, or the ready bits flip at the wrong fill level. A drifting region base would make egress and ingress entries overwrite each other in the shared store, and the next head read of the damaged queue shows it. A miscounted coalescing state moves the rx_event pulse by one or more cycles, which a per-cycle reference catches the first time an event is due.

// File: rtl/faq_pkg.sv
package faq_pkg;

   // register offsets
   localparam logic [7:0] OFS_STATUS  = 8'h00;
   localparam logic [7:0] OFS_TX_ADDR = 8'h04;
   localparam logic [7:0] OFS_TX_LEN  = 8'h08;
   localparam logic [7:0] OFS_RX_ADDR = 8'h0C;
   localparam logic [7:0] OFS_RX_DESC = 8'h10;
   localparam logic [7:0] OFS_DEPTH   = 8'h14;
   localparam logic [7:0] OFS_COAL    = 8'h18;

   // status bit positions
   localparam int ST_TX_RDY = 24;
   localparam int ST_RX_RDY = 25;
   localparam int ST_TX_OVF = 26;
   localparam int ST_RX_OVF = 27;

   // coalescing field widths (fixed by register layout)
   localparam int THR_W = 8;
   localparam int TMR_W = 16;

   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic [TMR_W-1:0] tmo;
   } coal_cfg_t;

endpackage

// File: rtl/faq_ring.sv
module faq_ring #(
   parameter int IDX_W = 6,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] base,
   input  logic [CNT_W-1:0] depth,
   input  logic             push,
   input  logic             pop,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             overflow,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   logic [CNT_W-1:0] wp;
   logic [CNT_W-1:0] rp;

   function automatic logic [CNT_W-1:0] adv(input logic [CNT_W-1:0] p,
                                            input logic [CNT_W-1:0] d);
      return (p == d - 1'b1) ? '0 : p + 1'b1;
   endfunction

   assign full     = (count >= depth);
   assign empty    = (count == '0);
   assign push_ok  = push && !full && !flush;
   assign pop_ok   = pop && !empty && !flush;
   assign overflow = push && full && !flush;
   assign wr_idx   = IDX_W'(CNT_W'(base) + wp);
   assign rd_idx   = IDX_W'(CNT_W'(base) + rp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= adv(wp, depth);
         if (pop_ok)  rp <= adv(rp, depth);
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= depth);  // R5
   AST_RING_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(push_ok) && !$past(pop_ok) && !$past(flush) |-> count == CNT_W'($past(count) + 1'b1));  // R3

endmodule

// File: rtl/faq_coalesce.sv
module faq_coalesce
   import faq_pkg::*;
#(
   parameter bit COALESCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame,
   input  logic [THR_W-1:0] thr,
   input  logic [TMR_W-1:0] tmo,
   output logic             fire_o
);

   generate
      if (COALESCE) begin : g_coal
         logic [THR_W-1:0] cnt;
         logic [TMR_W-1:0] tmr;
         logic [THR_W-1:0] thr_eff;
         logic [THR_W:0]   cnt_inc;
         logic             by_count;
         logic             by_time;
         logic             fire_c;

         assign thr_eff  = (thr == '0) ? THR_W'(1) : thr;
         assign cnt_inc  = {1'b0, cnt} + (THR_W+1)'(frame);
         assign by_count = frame && (cnt_inc >= {1'b0, thr_eff});
         assign by_time  = (cnt != '0) && (({1'b0, tmr} + 1'b1) >= {1'b0, tmo});
         assign fire_c   = by_count || by_time;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               tmr    <= '0;
               fire_o <= 1'b0;
            end else if (fire_c) begin
               cnt    <= '0;
               tmr    <= '0;
               fire_o <= 1'b1;
            end else begin
               cnt    <= cnt_inc[THR_W-1:0];
               tmr    <= (cnt != '0) ? tmr + 1'b1 : '0;
               fire_o <= 1'b0;
            end
         end

         AST_EVT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cnt) == '0 && !$past(frame) |-> !fire_o);  // R10
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fire_o <= 1'b0;
            else        fire_o <= frame;
         end
      end
   endgenerate

endmodule

// File: rtl/faq_mgr.sv
module faq_mgr
   import faq_pkg::*;
#(
   parameter int TOTAL    = 64,
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 12,
   parameter int TX_DEF   = 12,
   parameter int RX_DEF   = 52,
   parameter int THR_DEF  = 8,
   parameter int TMO_DEF  = 'h74,
   parameter int PEND_W   = 8,
   parameter bit COALESCE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [7:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              tx_head_valid,
   output logic [ADDR_W-1:0] tx_head_addr,
   output logic [LEN_W-1:0]  tx_head_len,
   input  logic              tx_done,
   output logic              rx_buf_valid,
   output logic [ADDR_W-1:0] rx_buf_addr,
   input  logic              rx_done,
   input  logic [LEN_W-1:0]  rx_len,
   output logic              rx_event
);

   localparam int IDX_W = $clog2(TOTAL);
   localparam int CNT_W = IDX_W + 1;

   generate
      if (TOTAL > 64 || TOTAL < 4) begin : g_bad_total
         $error("TOTAL must be within 4..64");
      end
      if (TX_DEF < 1 || RX_DEF < 1 || TX_DEF + RX_DEF > TOTAL) begin : g_bad_split
         $error("default split does not fit the store");
      end
      if (ADDR_W != 32 || LEN_W > 12 || PEND_W > 8 || PEND_W < 1) begin : g_bad_width
         $error("field width out of range");
      end
   endgenerate

   // ---------------- register decode ----------------
   logic wr_depth, wr_txa, wr_txl, wr_rxa, wr_stat, wr_coal;
   logic [7:0] d_tx, d_rx;
   logic       depth_ok;

   assign wr_stat  = wr_en && (wr_addr == OFS_STATUS);
   assign wr_txa   = wr_en && (wr_addr == OFS_TX_ADDR);
   assign wr_txl   = wr_en && (wr_addr == OFS_TX_LEN);
   assign wr_rxa   = wr_en && (wr_addr == OFS_RX_ADDR);
   assign wr_depth = wr_en && (wr_addr == OFS_DEPTH);
   assign wr_coal  = wr_en && (wr_addr == OFS_COAL);
   assign d_tx     = wr_data[7:0];
   assign d_rx     = wr_data[15:8];
   assign depth_ok = wr_depth && (d_tx != 8'd0) && (d_rx != 8'd0) &&
                     (({1'b0, d_tx} + {1'b0, d_rx}) <= 9'(TOTAL));

   // ---------------- configuration ----------------
   logic [CNT_W-1:0] tx_depth, rx_depth;
   coal_cfg_t        coal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_depth <= CNT_W'(TX_DEF);
         rx_depth <= CNT_W'(RX_DEF);
         coal.thr <= THR_W'(THR_DEF);
         coal.tmo <= TMR_W'(TMO_DEF);
      end else begin
         if (depth_ok) begin
            tx_depth <= CNT_W'(d_tx);
            rx_depth <= CNT_W'(d_rx);
         end
         if (wr_coal) begin
            coal.thr <= wr_data[31:24];
            coal.tmo <= wr_data[15:0];
         end
      end
   end

   // ---------------- egress staging ----------------
   logic              staged;
   logic [ADDR_W-1:0] staged_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged      <= 1'b0;
         staged_addr <= '0;
      end else if (depth_ok || wr_txl) begin
         staged <= 1'b0;
      end else if (wr_txa) begin
         staged      <= 1'b1;
         staged_addr <= wr_data[ADDR_W-1:0];
      end
   end

   // ---------------- the two rings ----------------
   logic             tx_push_ok, tx_pop_ok, tx_ovf_ev, tx_full, tx_empty;
   logic             rx_push_ok, rx_pop_ok, rx_ovf_ev, rx_full, rx_empty;
   logic [IDX_W-1:0] tx_wr_idx, tx_rd_idx, rx_wr_idx, rx_rd_idx;
   logic [CNT_W-1:0] tx_count, rx_count;

   faq_ring #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (depth_ok),
      .base     ('0),
      .depth    (tx_depth),
      .push     (wr_txl && staged),
      .pop      (tx_done),
      .push_ok  (tx_push_ok),
      .pop_ok   (tx_pop_ok),
      .overflow (tx_ovf_ev),
      .wr_idx   (tx_wr_idx),
      .rd_idx   (tx_rd_idx),
      .count    (tx_count),
      .full     (tx_full),
      .empty    (tx_empty)
   );

   faq_ring #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (depth_ok),
      .base     (tx_depth[IDX_W-1:0]),
      .depth    (rx_depth),
      .push     (wr_rxa),
      .pop      (rx_done),
      .push_ok  (rx_push_ok),
      .pop_ok   (rx_pop_ok),
      .overflow (rx_ovf_ev),
      .wr_idx   (rx_wr_idx),
      .rd_idx   (rx_rd_idx),
      .count    (rx_count),
      .full     (rx_full),
      .empty    (rx_empty)
   );

   // ---------------- shared address store ----------------
   logic [ADDR_W-1:0] store [TOTAL];
   logic [LEN_W-1:0]  tx_lens [TOTAL];

   always_ff @(posedge clk) begin
      if (tx_push_ok) begin
         store[tx_wr_idx]   <= staged_addr;
         tx_lens[tx_wr_idx] <= wr_data[LEN_W-1:0];
      end
      if (rx_push_ok) begin
         store[rx_wr_idx] <= wr_data[ADDR_W-1:0];
      end
   end

   assign tx_head_valid = !tx_empty;
   assign tx_head_addr  = store[tx_rd_idx];
   assign tx_head_len   = tx_lens[tx_rd_idx];
   assign rx_buf_valid  = !rx_empty;
   assign rx_buf_addr   = store[rx_rd_idx];

   // ---------------- overflow flags ----------------
   logic ovf_tx, ovf_rx, clr_tx, clr_rx;

   assign clr_tx = wr_stat && wr_data[ST_TX_OVF];
   assign clr_rx = wr_stat && wr_data[ST_RX_OVF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_tx <= 1'b0;
         ovf_rx <= 1'b0;
      end else begin
         if (tx_ovf_ev)   ovf_tx <= 1'b1;
         else if (clr_tx) ovf_tx <= 1'b0;
         if (rx_ovf_ev)   ovf_rx <= 1'b1;
         else if (clr_rx) ovf_rx <= 1'b0;
      end
   end

   // ---------------- completed receive frames ----------------
   logic [PEND_W-1:0] pend;
   logic [LEN_W-1:0]  last_len;
   logic              desc_pop, pend_inc;

   assign desc_pop = rd_en && (rd_addr == OFS_RX_DESC) && (pend != '0);
   assign pend_inc = rx_pop_ok && ((pend != '1) || desc_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= '0;
         last_len <= '0;
      end else begin
         pend <= pend + PEND_W'(pend_inc) - PEND_W'(desc_pop);
         if (rx_pop_ok) last_len <= rx_len;
      end
   end

   faq_coalesce #(.COALESCE(COALESCE)) u_coal (
      .clk    (clk),
      .rst_n  (rst_n),
      .frame  (rx_pop_ok),
      .thr    (coal.thr),
      .tmo    (coal.tmo),
      .fire_o (rx_event)
   );

   // ---------------- read mux ----------------
   logic [31:0] status_w, desc_w;

   always_comb begin
      status_w             = '0;
      status_w[CNT_W-1:0]  = tx_count;
      status_w[ST_TX_RDY]  = !tx_full;
      status_w[ST_RX_RDY]  = !rx_full;
      status_w[ST_TX_OVF]  = ovf_tx;
      status_w[ST_RX_OVF]  = ovf_rx;
      desc_w               = '0;
      desc_w[LEN_W-1:0]    = last_len;
      desc_w[16 +: PEND_W] = pend;
      desc_w[24 +: CNT_W]  = rx_count;
   end

   always_comb begin
      case (rd_addr)
         OFS_STATUS:  rd_data = status_w;
         OFS_RX_DESC: rd_data = desc_w;
         OFS_DEPTH:   rd_data = {16'h0, 8'(rx_depth), 8'(tx_depth)};
         OFS_COAL:    rd_data = {coal.thr, 8'h0, coal.tmo};
         default:     rd_data = '0;
      endcase
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_tx) && !$past(clr_tx) |-> ovf_tx);  // R6
   AST_DESC_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      $past(desc_pop) && !$past(rx_pop_ok) |-> pend == PEND_W'($past(pend) - 1'b1));  // R8
   AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_pop_ok) && $past(tx_count) == CNT_W'(1) && !$past(tx_push_ok) |-> !tx_head_valid);  // R4

endmodule

// File: tb/test_faq_mgr.sv
`timescale 1ns/1ps
module test_faq_mgr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        tx_head_valid;
   logic [31:0] tx_head_addr;
   logic [11:0] tx_head_len;
   logic        tx_done = 1'b0;
   logic        rx_buf_valid;
   logic [31:0] rx_buf_addr;
   logic        rx_done = 1'b0;
   logic [11:0] rx_len = '0;
   logic        rx_event;

   always #2.5 clk = ~clk;

   faq_mgr i_faq_mgr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_head_valid(tx_head_valid), .tx_head_addr(tx_head_addr), .tx_head_len(tx_head_len),
      .tx_done(tx_done), .rx_buf_valid(rx_buf_valid), .rx_buf_addr(rx_buf_addr),
      .rx_done(rx_done), .rx_len(rx_len), .rx_event(rx_event)
   );

   int nchk = 0;
   int nerr = 0;

   // reference state
   logic [31:0] m_txa[$];
   logic [11:0] m_txl[$];
   logic [31:0] m_rxa[$];
   int          m_txd = 12, m_rxd = 52;
   bit          m_staged = 0;
   logic [31:0] m_saddr = '0;
   bit          m_ovt = 0, m_ovr = 0;
   int          m_pend = 0;
   logic [11:0] m_last = '0;
   int          m_thr = 8, m_tmo = 'h74;
   int          m_cnt = 0, m_tmr = 0;
   bit          m_evt = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         8'h00: v = {4'b0, m_ovr, m_ovt, m_rxa.size() < m_rxd, m_txa.size() < m_txd, 18'b0, 6'(m_txa.size())};
         8'h10: v = {1'b0, 7'(m_rxa.size()), 8'(m_pend), 4'h0, m_last};
         8'h14: v = {16'h0, 8'(m_rxd), 8'(m_txd)};
         8'h18: v = {8'(m_thr), 8'h0, 16'(m_tmo)};
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic string rd_tag(input logic [7:0] a);
      case (a)
         8'h00: return "R3 R5 R6 R11 status";
         8'h10: return "R8 descriptor";
         8'h14: return "R2 depth";
         8'h18: return "R9 coalescing";
         default: return "R2 unmapped";
      endcase
   endfunction

   function automatic void model_step();
      int  txn, rxn, thr_e, dtx, drx;
      bit  flush, txpop, rxpop, dpop, fire;
      txn   = m_txa.size();
      rxn   = m_rxa.size();
      dtx   = int'(wr_data[7:0]);
      drx   = int'(wr_data[15:8]);
      flush = wr_en && wr_addr == 8'h14 && dtx != 0 && drx != 0 && dtx + drx <= 64;
      txpop = tx_done && txn > 0 && !flush;
      rxpop = rx_done && rxn > 0 && !flush;
      dpop  = rd_en && rd_addr == 8'h10 && m_pend != 0;
      // coalescing with pre-edge settings
      thr_e = (m_thr == 0) ? 1 : m_thr;
      fire  = (rxpop && m_cnt + 1 >= thr_e) || (m_cnt != 0 && m_tmr + 1 >= m_tmo);
      if (fire) begin
         m_cnt = 0; m_tmr = 0; m_evt = 1;
      end else begin
         m_tmr = (m_cnt != 0) ? m_tmr + 1 : 0;
         m_cnt = m_cnt + int'(rxpop);
         m_evt = 0;
      end
      if (rxpop && (m_pend != 255 || dpop)) m_pend++;
      if (dpop) m_pend--;
      if (rxpop) m_last = rx_len;
      if (flush) begin
         m_txa.delete(); m_txl.delete(); m_rxa.delete();
         m_staged = 0; m_txd = dtx; m_rxd = drx;
      end else begin
         if (txpop) begin void'(m_txa.pop_front()); void'(m_txl.pop_front()); end
         if (rxpop) void'(m_rxa.pop_front());
         if (wr_en && wr_addr == 8'h08) begin
            if (m_staged) begin
               if (txn < m_txd) begin m_txa.push_back(m_saddr); m_txl.push_back(wr_data[11:0]); end
               else m_ovt = 1;
            end
            m_staged = 0;
         end
         if (wr_en && wr_addr == 8'h04) begin m_staged = 1; m_saddr = wr_data; end
         if (wr_en && wr_addr == 8'h0C) begin
            if (rxn < m_rxd) m_rxa.push_back(wr_data);
            else m_ovr = 1;
         end
         if (wr_en && wr_addr == 8'h00) begin
            if (wr_data[26]) m_ovt = 0;
            if (wr_data[27]) m_ovr = 0;
         end
      end
      if (wr_en && wr_addr == 8'h18) begin
         m_thr = int'(wr_data[31:24]); m_tmo = int'(wr_data[15:0]);
      end
   endfunction

   task automatic check_all();
      chk("R4 tx head valid", 32'(tx_head_valid), 32'(m_txa.size() > 0));
      if (m_txa.size() > 0) begin
         chk("R4 tx head addr", tx_head_addr, m_txa[0]);
         chk("R4 tx head len", 32'(tx_head_len), 32'(m_txl[0]));
      end
      chk("R7 rx buf valid", 32'(rx_buf_valid), 32'(m_rxa.size() > 0));
      if (m_rxa.size() > 0) chk("R7 rx buf addr", rx_buf_addr, m_rxa[0]);
      chk("R9 R10 rx event", 32'(rx_event), 32'(m_evt));
      chk(rd_tag(rd_addr), rd_data, exp_rd(rd_addr));
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      model_step();
      check_all();
      @(negedge clk);
      wr_en = 0; rd_en = 0; tx_done = 0; rx_done = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      cyc();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd_addr = 8'h00; #1 chk("R1 status after reset", rd_data, 32'h0300_0000);
      rd_addr = 8'h14; #1 chk("R1 depth after reset", rd_data, 32'h0000_340C);
      rd_addr = 8'h18; #1 chk("R1 coalescing after reset", rd_data, 32'h0800_0074);
      chk("R1 heads idle", {29'b0, tx_head_valid, rx_buf_valid, rx_event}, 32'h0);
      @(negedge clk);

      // R2 rejected split (sum 80)
      rd_addr = 8'h14;
      wr(8'h14, 32'h0000_3020);
      wr(8'h14, 32'h0000_0500);   // zero egress share, rejected
      // R3 length without staged address is ignored
      rd_addr = 8'h00;
      wr(8'h08, 32'h0000_0040);
      // R4 retire on empty queue is ignored
      tx_done = 1; cyc();
      // small split: egress 2, ingress 3
      wr(8'h14, 32'h0000_0302);
      wr(8'h04, 32'h1000_0000); wr(8'h08, 32'h0000_0044);
      wr(8'h04, 32'h1000_0100); wr(8'h08, 32'h0000_0104);
      wr(8'h04, 32'h1000_0200); wr(8'h08, 32'h0000_0204);   // R6 overflow
      // R5 full queue refuses a push even with a pop in the same cycle
      wr_en = 1; wr_addr = 8'h04; wr_data = 32'h1000_0300; cyc();
      tx_done = 1; wr_en = 1; wr_addr = 8'h08; wr_data = 32'h0000_0304; cyc();
      wr(8'h00, 32'h0400_0000);   // R6 clear
      // R7 ingress and R9 count coalescing
      wr(8'h18, 32'h0200_0006);
      wr(8'h0C, 32'h2000_0000); wr(8'h0C, 32'h2000_0040); wr(8'h0C, 32'h2000_0080);
      wr(8'h0C, 32'h2000_00C0);   // R6 ingress overflow
      rx_done = 1; rx_len = 12'h05E; cyc();
      rx_done = 1; rx_len = 12'h3F0; cyc();
      // R10 timeout with one frame outstanding
      rx_done = 1; rx_len = 12'h100; cyc();
      idle(9);
      // R8 drain descriptor
      rd_addr = 8'h10;
      for (int i = 0; i < 4; i++) begin rd_en = 1; cyc(); end
      // R11 flush while entries are held, with a pop in the same cycle
      wr(8'h04, 32'h3000_0000); wr(8'h08, 32'h0000_0080);
      wr(8'h0C, 32'h4000_0000);
      tx_done = 1; rx_done = 1; wr_en = 1; wr_addr = 8'h14; wr_data = 32'h0000_0404; cyc();
      rd_addr = 8'h00; cyc();

      // random phase
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         wr_data = $urandom();
         if (r < 20)      begin wr_en = 1; wr_addr = 8'h04; end
         else if (r < 40) begin wr_en = 1; wr_addr = 8'h08; end
         else if (r < 62) begin wr_en = 1; wr_addr = 8'h0C; end
         else if (r < 66) begin wr_en = 1; wr_addr = 8'h00; end
         else if (r < 68) begin
            wr_en = 1; wr_addr = 8'h14;
            wr_data = {16'h0, 8'($urandom_range(0, 7)), 8'($urandom_range(0, 7))};
         end else if (r < 70) begin
            wr_en = 1; wr_addr = 8'h18;
            wr_data = {8'($urandom_range(0, 4)), 8'h0, 16'($urandom_range(0, 15))};
         end
         tx_done = ($urandom_range(0, 99) < 35);
         rx_done = ($urandom_range(0, 99) < 35);
         rx_len  = 12'($urandom());
         rd_en   = ($urandom_range(0, 99) < 40);
         case ($urandom_range(0, 3))
            0: rd_addr = 8'h00;
            1: rd_addr = 8'h10;
            2: rd_addr = 8'h14;
            default: rd_addr = 8'h18;
         endcase
         cyc();
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule